// File: doc/BRIEF.md
# DRAM Refresh Sequencer with Self-Refresh

This block decides when a DRAM array is refreshed and which row is refreshed. It watches the row-enable strobe and the control inputs sampled at its falling edge. A refresh request at that edge starts a refresh cycle that takes its row from an internal counter. A particular strobe combination instead enters self-refresh, in which an interval timer issues refreshes for as long as row enable stays low. When row enable returns high after self-refresh, a guard interval starts. Any fall of row enable during the guard interval is ignored.

Refresh cycles started by a falling edge are hidden: the cache-read permission stays high while they run. A window monitor counts refresh strobes in fixed windows of clock cycles and raises a sticky flag if a window ends short of the required count. A start-up tracker raises an init-done flag once the start-up rule has been met after row enable has been held high long enough. A parameter selects a variant in which the refresh input and the column-latch input are one shared pin, so a low column latch at the fall of row enable requests the refresh.

All inputs are synchronous to `clk`. A fall of row enable is a clock edge that samples `row_en_n` low after the previous edge sampled it high.

Top module: `rfsh_seq`

## Requirements
- R1: After reset, `rfsh_stb`, `rfsh_busy`, `self_act`, `guard_busy`, `init_done` and `rfsh_viol` are 0, `rfsh_row` is 0 and `cache_rd_ok` is 1.
- R2: If the refresh trigger (`rfsh_n`, or `col_lat_n` when CBR_TIED=1) is low at an accepted fall of row enable, `rfsh_stb` is high for exactly the next cycle. In that cycle `rfsh_row` equals the refresh counter. `col_lat_n`, `wr_rd`, `wen_n`, `sel_n` and `row_addr` have no effect on this.
- R3: The refresh counter starts at 0. It advances by one when row enable rises to end a refresh cycle, and once after each self-refresh strobe. It wraps modulo 2^ROW_W.
- R4: While a refresh cycle started by a fall of row enable is running, `rfsh_busy` is 1 and `cache_rd_ok` stays 1.
- R5: With CBR_TIED=0, an accepted fall with `sel_n`=1, `wr_rd`=1, `rfsh_n`=1, `wen_n`=1 and `col_lat_n`=0 enters self-refresh: `self_act` is 1 from the next cycle until the edge that samples row enable high.
- R6: In self-refresh, a strobe appears every SR_INT cycles. The first strobe comes SR_INT cycles after the cycle in which `self_act` first reads 1, and each strobe carries the current counter value.
- R7: Leaving self-refresh makes `guard_busy` 1 for GUARD cycles. `cache_rd_ok` is 0 during self-refresh and during the guard. A fall of row enable during the guard starts nothing and leaves the counter unchanged.
- R8: With CBR_TIED=1, a low `col_lat_n` at a fall of row enable starts a refresh whatever `rfsh_n` is, and a low `rfsh_n` with a high `col_lat_n` starts none.
- R9: Window k covers clock cycles k·PERIOD to k·PERIOD+PERIOD−1, counted from reset release. If fewer than MIN_REFS strobe cycles fall in window k, `rfsh_viol` is 1 from cycle (k+1)·PERIOD onward and stays 1 until reset.
- R10: Falls of row enable count toward start-up only after row enable has been sampled high on PRE_HIGH consecutive edges.
- R11: `init_done` becomes 1 in the cycle after the fall that completes INIT_REFS counted refresh cycles and INIT_READS reads to distinct rows. A read here is a fall with `sel_n`=0 and `wr_rd`=0, and a read counts only if its row differs from the previous read's row. Once set, `init_done` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_en_n | input | 1 | Row enable, active low |
| rfsh_n | input | 1 | Refresh request, active low |
| col_lat_n | input | 1 | Column latch, active low |
| wr_rd | input | 1 | 1 selects write, 0 selects read |
| wen_n | input | 1 | Write enable, active low |
| sel_n | input | 1 | Chip select, active low |
| row_addr | input | RA_W | Row address presented at the row-enable fall |
| rfsh_stb | output | 1 | One-cycle refresh strobe |
| rfsh_row | output | ROW_W | Row being refreshed, valid with the strobe |
| rfsh_busy | output | 1 | A refresh cycle or self-refresh is in progress |
| self_act | output | 1 | Self-refresh is active |
| guard_busy | output | 1 | Guard interval after self-refresh exit |
| cache_rd_ok | output | 1 | Cache reads are permitted |
| init_done | output | 1 | Start-up rule satisfied |
| rfsh_viol | output | 1 | Sticky flag for a refresh window that ended short |

## Verification
The bench drives inputs on the falling clock edge and samples one full cycle later. This matches the single register between a sampled fall of row enable and the strobe, the busy and self-refresh flags, and the start-up counters. The counter advance lands on the edge that samples row enable high, so the next strobe's row shows it. Self-refresh strobes are expected on samples that are exact multiples of SR_INT after entry. The guard flag is expected for exactly GUARD samples after the exit sample. A per-cycle monitor numbers cycles from reset release, closes each window at the sample whose index is a multiple of PERIOD, and compares the violation flag against its own count of observed strobes.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  // Class of a sampled row-enable fall
  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_RFSH  = 3'd1,
    EV_SELF  = 3'd2,
    EV_READ  = 3'd3,
    EV_OTHER = 3'd4
  } fall_ev_e;

  // Strobe combination that requests self-refresh
  function automatic logic self_combo(input logic sel_n, input logic wr_rd,
                                      input logic rfsh_n, input logic wen_n,
                                      input logic col_lat_n);
    return sel_n & wr_rd & rfsh_n & wen_n & ~col_lat_n;
  endfunction

  // Window compliance test
  function automatic logic window_short(input int unsigned have,
                                        input int unsigned need);
    return have < need;
  endfunction

endpackage

// File: rtl/rfsh_decode.sv
module rfsh_decode
  import rfsh_pkg::*;
#(
  parameter bit CBR_TIED = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     row_en_n,
  input  logic     rfsh_n,
  input  logic     col_lat_n,
  input  logic     wr_rd,
  input  logic     wen_n,
  input  logic     sel_n,
  output logic     fall,
  output fall_ev_e ev
);

  logic re_prev;
  logic trig_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) re_prev <= 1'b1;
    else        re_prev <= row_en_n;
  end

  assign fall = re_prev & ~row_en_n;

  generate
    if (CBR_TIED) begin : g_tied
      assign trig_n = col_lat_n;
    end else begin : g_split
      assign trig_n = rfsh_n;
    end
  endgenerate

  always_comb begin
    ev = EV_NONE;
    if (fall) begin
      if (!trig_n)
        ev = EV_RFSH;
      else if (self_combo(sel_n, wr_rd, rfsh_n, wen_n, col_lat_n))
        ev = EV_SELF;
      else if (!sel_n && !wr_rd)
        ev = EV_READ;
      else
        ev = EV_OTHER;
    end
  end

endmodule

// File: rtl/rfsh_engine.sv
module rfsh_engine
  import rfsh_pkg::*;
#(
  parameter int ROW_W  = 10,
  parameter int SR_INT = 7800,
  parameter int GUARD  = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en_n,
  input  fall_ev_e         ev,
  output logic             idle,
  output logic             stb,
  output logic [ROW_W-1:0] row,
  output logic [ROW_W-1:0] ctr,
  output logic             in_ext,
  output logic             in_self,
  output logic             guard_busy,
  output logic             ctr_adv
);

  localparam int TW = (SR_INT > 1) ? $clog2(SR_INT) : 1;
  localparam int GW = $clog2(GUARD + 1);

  logic [TW-1:0] tmr;
  logic [GW-1:0] gcnt;
  logic          stb_self;

  function automatic logic [ROW_W-1:0] next_row(input logic [ROW_W-1:0] r);
    return r + 1'b1;
  endfunction

  assign idle       = ~in_ext & ~in_self & (gcnt == '0);
  assign guard_busy = (gcnt != '0);
  assign ctr_adv    = (in_ext & row_en_n) | stb_self;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr      <= '0;
      row      <= '0;
      stb      <= 1'b0;
      stb_self <= 1'b0;
      in_ext   <= 1'b0;
      in_self  <= 1'b0;
      tmr      <= '0;
      gcnt     <= '0;
    end else begin
      stb      <= 1'b0;
      stb_self <= 1'b0;
      if (gcnt != '0) gcnt <= gcnt - 1'b1;
      if (ctr_adv) ctr <= next_row(ctr);

      if (in_self) begin
        if (row_en_n) begin
          in_self <= 1'b0;
          gcnt    <= GW'(GUARD);
        end else if (tmr == TW'(SR_INT - 1)) begin
          tmr      <= '0;
          stb      <= 1'b1;
          stb_self <= 1'b1;
          row      <= ctr;
        end else begin
          tmr <= tmr + 1'b1;
        end
      end else if (in_ext) begin
        if (row_en_n) in_ext <= 1'b0;
      end else begin
        case (ev)
          EV_RFSH: begin
            in_ext <= 1'b1;
            stb    <= 1'b1;
            row    <= ctr;
          end
          EV_SELF: begin
            in_self <= 1'b1;
            tmr     <= '0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rfsh_window.sv
module rfsh_window
  import rfsh_pkg::*;
#(
  parameter int PERIOD   = 8000000,
  parameter int MIN_REFS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  output logic win_end,
  output logic viol
);

  localparam int WCW = $clog2(PERIOD);
  localparam int RCW = $clog2(MIN_REFS + 1);

  logic [WCW-1:0] wc;
  logic [RCW-1:0] refs;
  logic [RCW:0]   refs_tot;

  assign win_end  = (wc == WCW'(PERIOD - 1));
  assign refs_tot = {1'b0, refs} + (RCW + 1)'(stb);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wc   <= '0;
      refs <= '0;
      viol <= 1'b0;
    end else if (win_end) begin
      wc   <= '0;
      refs <= '0;
      if (window_short(int'(refs_tot), MIN_REFS)) viol <= 1'b1;
    end else begin
      wc <= wc + 1'b1;
      if (stb && refs != RCW'(MIN_REFS)) refs <= refs + 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_init.sv
module rfsh_init
  import rfsh_pkg::*;
#(
  parameter int RA_W       = 11,
  parameter int PRE_HIGH   = 38,
  parameter int INIT_REFS  = 8,
  parameter int INIT_READS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_en_n,
  input  fall_ev_e        ev,
  input  logic [RA_W-1:0] row_addr,
  output logic            armed,
  output logic            init_done
);

  localparam int HW  = $clog2(PRE_HIGH + 1);
  localparam int RFW = $clog2(INIT_REFS + 1);
  localparam int RDW = $clog2(INIT_READS + 1);

  logic [HW-1:0]   hi_cnt;
  logic [RFW-1:0]  rf_cnt;
  logic [RDW-1:0]  rd_cnt;
  logic [RA_W-1:0] last_row;
  logic            have_row;
  logic            new_row;

  assign new_row   = ~have_row | (row_addr != last_row);
  assign init_done = armed & (rf_cnt == RFW'(INIT_REFS)) & (rd_cnt == RDW'(INIT_READS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt   <= '0;
      armed    <= 1'b0;
      rf_cnt   <= '0;
      rd_cnt   <= '0;
      last_row <= '0;
      have_row <= 1'b0;
    end else if (!armed) begin
      if (row_en_n) begin
        if (hi_cnt == HW'(PRE_HIGH - 1)) armed  <= 1'b1;
        else                             hi_cnt <= hi_cnt + 1'b1;
      end else begin
        hi_cnt <= '0;
      end
    end else begin
      if (ev == EV_RFSH && rf_cnt != RFW'(INIT_REFS)) rf_cnt <= rf_cnt + 1'b1;
      if (ev == EV_READ) begin
        if (new_row && rd_cnt != RDW'(INIT_READS)) rd_cnt <= rd_cnt + 1'b1;
        last_row <= row_addr;
        have_row <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROW_W      = 10,
  parameter int RA_W       = 11,
  parameter int PERIOD     = 8000000,
  parameter int MIN_REFS   = 1024,
  parameter int SR_INT     = 7800,
  parameter int GUARD      = 13,
  parameter int PRE_HIGH   = 38,
  parameter int INIT_REFS  = 8,
  parameter int INIT_READS = 2,
  parameter bit CBR_TIED   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_en_n,
  input  logic             rfsh_n,
  input  logic             col_lat_n,
  input  logic             wr_rd,
  input  logic             wen_n,
  input  logic             sel_n,
  input  logic [RA_W-1:0]  row_addr,
  output logic             rfsh_stb,
  output logic [ROW_W-1:0] rfsh_row,
  output logic             rfsh_busy,
  output logic             self_act,
  output logic             guard_busy,
  output logic             cache_rd_ok,
  output logic             init_done,
  output logic             rfsh_viol
);

  // Named internal events, visible to the bound checker
  fall_ev_e         ev_raw;
  fall_ev_e         ev_acc;
  logic             fall;
  logic             idle;
  logic             in_ext;
  logic [ROW_W-1:0] ctr;
  logic             ctr_adv;
  logic             win_end;
  logic             armed;

  rfsh_decode #(.CBR_TIED(CBR_TIED)) u_dec (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n),
    .col_lat_n(col_lat_n), .wr_rd(wr_rd), .wen_n(wen_n), .sel_n(sel_n),
    .fall(fall), .ev(ev_raw)
  );

  assign ev_acc = idle ? ev_raw : EV_NONE;

  rfsh_engine #(.ROW_W(ROW_W), .SR_INT(SR_INT), .GUARD(GUARD)) u_eng (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .ev(ev_acc),
    .idle(idle), .stb(rfsh_stb), .row(rfsh_row), .ctr(ctr),
    .in_ext(in_ext), .in_self(self_act), .guard_busy(guard_busy),
    .ctr_adv(ctr_adv)
  );

  rfsh_window #(.PERIOD(PERIOD), .MIN_REFS(MIN_REFS)) u_win (
    .clk(clk), .rst_n(rst_n), .stb(rfsh_stb), .win_end(win_end), .viol(rfsh_viol)
  );

  rfsh_init #(.RA_W(RA_W), .PRE_HIGH(PRE_HIGH), .INIT_REFS(INIT_REFS),
              .INIT_READS(INIT_READS)) u_init (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .ev(ev_acc),
    .row_addr(row_addr), .armed(armed), .init_done(init_done)
  );

  assign rfsh_busy   = in_ext | self_act;
  assign cache_rd_ok = ~self_act & ~guard_busy;

endmodule

// File: rtl/rfsh_seq_chk.sv
module rfsh_seq_chk #(
  parameter int ROW_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_en_n,
  input logic             rfsh_stb,
  input logic             rfsh_busy,
  input logic             self_act,
  input logic             guard_busy,
  input logic             cache_rd_ok,
  input logic             init_done,
  input logic             rfsh_viol,
  input logic [ROW_W-1:0] ctr
);

  a_r2_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |=> !rfsh_stb);

  a_r2_stb_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_stb |-> rfsh_busy);

  a_r3_ctr_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctr) |-> ctr == ROW_W'($past(ctr) + 1'b1));

  a_r4_hidden_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rfsh_busy && !self_act) |-> cache_rd_ok);

  a_r5_self_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (self_act && row_en_n) |=> !self_act);

  a_r7_guard_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(self_act) |-> guard_busy);

  a_r7_guard_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    guard_busy |-> (!rfsh_stb && !rfsh_busy && !cache_rd_ok));

  a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rfsh_viol |=> rfsh_viol);

  a_r11_init_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

endmodule

bind rfsh_seq rfsh_seq_chk #(.ROW_W(ROW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_stb(rfsh_stb),
  .rfsh_busy(rfsh_busy), .self_act(self_act), .guard_busy(guard_busy),
  .cache_rd_ok(cache_rd_ok), .init_done(init_done), .rfsh_viol(rfsh_viol),
  .ctr(ctr)
);

// File: tb/rfsh_seq_tb.sv
module rfsh_seq_tb;

  localparam int ROW_W = 3;
  localparam int RA_W  = 4;
  localparam int W     = 64;
  localparam int MINR  = 4;
  localparam int SR    = 5;
  localparam int GRD   = 4;
  localparam int PRE   = 6;
  localparam int IREF  = 8;
  localparam int IRD   = 2;
  localparam int NROWS = 1 << ROW_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_en_n = 1'b1, rfsh_n = 1'b1, col_lat_n = 1'b1;
  logic wr_rd = 1'b0, wen_n = 1'b1, sel_n = 1'b1;
  logic [RA_W-1:0] row_addr = '0;

  logic             stb, busy, self_act, guard, rd_ok, idone, viol;
  logic [ROW_W-1:0] row;
  logic             c_stb, c_busy, c_self, c_guard, c_rd_ok, c_idone, c_viol;
  logic [ROW_W-1:0] c_row;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int exp_ctr  = 0;
  int exp_tctr = 0;

  always #4 clk = ~clk;

  rfsh_seq #(.ROW_W(ROW_W), .RA_W(RA_W), .PERIOD(W), .MIN_REFS(MINR),
             .SR_INT(SR), .GUARD(GRD), .PRE_HIGH(PRE), .INIT_REFS(IREF),
             .INIT_READS(IRD), .CBR_TIED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n),
    .col_lat_n(col_lat_n), .wr_rd(wr_rd), .wen_n(wen_n), .sel_n(sel_n),
    .row_addr(row_addr), .rfsh_stb(stb), .rfsh_row(row), .rfsh_busy(busy),
    .self_act(self_act), .guard_busy(guard), .cache_rd_ok(rd_ok),
    .init_done(idone), .rfsh_viol(viol)
  );

  rfsh_seq #(.ROW_W(ROW_W), .RA_W(RA_W), .PERIOD(W), .MIN_REFS(MINR),
             .SR_INT(SR), .GUARD(GRD), .PRE_HIGH(PRE), .INIT_REFS(IREF),
             .INIT_READS(IRD), .CBR_TIED(1'b1)) u_dut_cbr (
    .clk(clk), .rst_n(rst_n), .row_en_n(row_en_n), .rfsh_n(rfsh_n),
    .col_lat_n(col_lat_n), .wr_rd(wr_rd), .wen_n(wen_n), .sel_n(sel_n),
    .row_addr(row_addr), .rfsh_stb(c_stb), .rfsh_row(c_row), .rfsh_busy(c_busy),
    .self_act(c_self), .guard_busy(c_guard), .cache_rd_ok(c_rd_ok),
    .init_done(c_idone), .rfsh_viol(c_viol)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_pins();
    row_en_n = 1'b1; rfsh_n = 1'b1; col_lat_n = 1'b1;
    wr_rd = 1'b0; wen_n = 1'b1; sel_n = 1'b1;
  endtask

  // R9 window model: per-cycle violation prediction from observed strobes
  int  cyc = 0;
  int  wcnt = 0;
  bit  exp_viol = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (cyc % W == 0) begin
        if (wcnt < MINR) exp_viol = 1'b1;
        wcnt = 0;
      end
      if (stb) wcnt++;
      check("R9 window flag", int'(viol), int'(exp_viol));
    end
  end

  // Refresh cycle through the refresh pin, with strobe/row/hidden-read checks
  task automatic do_refresh(input string tag);
    rfsh_n = 1'b0; row_en_n = 1'b0;
    step();
    check({tag, " R2 strobe"}, int'(stb), 1);
    check({tag, " R2 R3 row"}, int'(row), exp_ctr);
    check({tag, " R4 busy"}, int'(busy), 1);
    check({tag, " R4 cache_rd_ok"}, int'(rd_ok), 1);
    idle_pins();
    step();
    exp_ctr = (exp_ctr + 1) % NROWS;
    check({tag, " R2 single strobe"}, int'(stb), 0);
  endtask

  task automatic do_read(input logic [RA_W-1:0] r);
    sel_n = 1'b0; wr_rd = 1'b0; row_addr = r; row_en_n = 1'b0;
    step();
    check("R2 read has no strobe", int'(stb), 0);
    idle_pins();
    step();
  endtask

  initial begin
    idle_pins();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1 reset state
    check("R1 stb", int'(stb), 0);
    check("R1 row", int'(row), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 self", int'(self_act), 0);
    check("R1 guard", int'(guard), 0);
    check("R1 cache_rd_ok", int'(rd_ok), 1);
    check("R1 init_done", int'(idone), 0);
    check("R1 viol", int'(viol), 0);

    // R10: this refresh falls before the high-time rule and must not count
    do_refresh("early");
    repeat (PRE + 2) step();

    // R11: reads to two different rows, then refreshes
    do_read(4'd3);
    do_read(4'd5);
    for (int k = 0; k < IREF - 1; k++) do_refresh("init");
    check("R10 early refresh not counted", int'(idone), 0);
    do_refresh("init last");
    check("R11 init_done", int'(idone), 1);
    check("R3 wrap", exp_ctr, 1);

    // Sweep every control combination at the row-enable fall
    for (int i = 0; i < 32; i++) begin
      logic [4:0] b;
      logic er, es, et;
      b = 5'(i);
      rfsh_n = b[0]; col_lat_n = b[1]; wr_rd = b[2]; wen_n = b[3]; sel_n = b[4];
      row_addr = b[3:0];
      er = ~b[0];
      es = b[0] & ~b[1] & b[2] & b[3] & b[4];
      et = ~b[1];
      row_en_n = 1'b0;
      step();
      check("R2 sweep strobe", int'(stb), int'(er));
      if (er) check("R2 sweep row", int'(row), exp_ctr);
      check("R5 sweep self entry", int'(self_act), int'(es));
      check("R8 tied strobe", int'(c_stb), int'(et));
      if (et) check("R8 tied row", int'(c_row), exp_tctr);
      idle_pins();
      step();
      if (er) exp_ctr = (exp_ctr + 1) % NROWS;
      if (et) exp_tctr = (exp_tctr + 1) % NROWS;
      if (es) begin
        check("R7 guard after exit", int'(guard), 1);
        repeat (GRD) step();
        check("R7 guard ended", int'(guard), 0);
      end
    end

    // R5/R6: long self-refresh
    sel_n = 1'b1; wr_rd = 1'b1; rfsh_n = 1'b1; wen_n = 1'b1; col_lat_n = 1'b0;
    row_en_n = 1'b0;
    step();
    check("R5 self active", int'(self_act), 1);
    check("R7 no cache read in self", int'(rd_ok), 0);
    check("R6 no strobe at entry", int'(stb), 0);
    for (int k = 1; k <= 3 * SR; k++) begin
      step();
      check("R6 self strobe timing", int'(stb), (k % SR == 0) ? 1 : 0);
      if (k % SR == 0) begin
        check("R6 self strobe row", int'(row), exp_ctr);
        exp_ctr = (exp_ctr + 1) % NROWS;
      end
      check("R5 self held", int'(self_act), 1);
    end
    idle_pins();
    step();
    check("R5 self exit", int'(self_act), 0);
    check("R7 guard start", int'(guard), 1);
    check("R7 no cache read in guard", int'(rd_ok), 0);
    // Fall during guard must be ignored
    rfsh_n = 1'b0; row_en_n = 1'b0;
    step();
    check("R7 fall in guard ignored", int'(stb), 0);
    idle_pins();
    step();
    check("R7 guard still busy", int'(guard), 1);
    step();
    check("R7 guard last cycle", int'(guard), 1);
    step();
    check("R7 guard over", int'(guard), 0);
    check("R7 cache read back", int'(rd_ok), 1);
    do_refresh("R7 counter unchanged by guard fall");

    // R9: starve the refresh windows
    repeat (3 * W) step();
    check("R9 violation raised", int'(viol), 1);
    do_refresh("post");
    check("R9 violation sticky", int'(viol), 1);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

endmodule